// File: doc/BRIEF.md
# Stepping Memory Exerciser Control

This block lets an operator walk through a small memory one location at a time. The operator picks a direction with a mode input, either storing the value on a set of switches or fetching the stored word. A debounced push-button then starts exactly one memory cycle at the location held in an internal address counter. When the step option is on, the counter advances by one once the cycle is over, so repeated presses visit the locations in order. A word fetched from memory is held in a display register until the next fetch replaces it. The counter value is also shown on a monitor output.

Each memory cycle lasts seven periods of `PHASE_CYCLES` clocks each, numbered 0 to 6. Every memory strobe is built from a range of those periods. The address is presented through the whole cycle. Chip select and write enable fall inside that window, and the switch drive falls inside the write enable window. Because of this nesting, the memory never sees an address change or data change while a strobe is active. All strobes are active high at the ports.

Top module: `mem_exerciser`

## Requirements
- R1: After reset the address counter is 0, the display register is 0, `busy` is low, and `memChipSel`, `memWriteEn` and `memDataOutEn` are low.
- R2: A rising edge on `pressIn` seen at a clock edge while idle starts one cycle. `busy` is high from the next clock for exactly 7×`PHASE_CYCLES` clocks. A press held high does not start a second cycle.
- R3: `memChipSel` is high in periods 1 through 5 of every cycle and low at all other times.
- R4: On a cycle started with `writeSel`=1, `memWriteEn` is high in periods 2 through 4. On a cycle started with `writeSel`=0 it stays low.
- R5: On a write cycle, `memDataOutEn` is high only in period 3, and during that period `memDataOut` equals `switchVal`. At all other times `memDataOutEn` is low.
- R6: On a read cycle, the display register takes `memDataIn` at the clock edge that ends period 5, and shows it from period 6 onward. At no other time does the display change.
- R7: `memAddr` and `addrMonitor` stay constant for the whole cycle. If `stepEn` was 1 when the cycle started, the address rises by one at the edge that ends period 6, wrapping from 15 to 0.
- R8: If `stepEn` was 0 when the cycle started, the address is unchanged after the cycle.
- R9: Rising edges on `pressIn` during an active cycle are ignored. No cycle follows unless a new edge arrives while idle.
- R10: `clearIn` high at a clock edge while idle sets the address to 0. While `busy` is high, `clearIn` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pressIn | input | 1 | Debounced push-button level |
| writeSel | input | 1 | 1 = store switches, 0 = fetch word; sampled at cycle start |
| stepEn | input | 1 | 1 = advance address after the cycle; sampled at cycle start |
| clearIn | input | 1 | Synchronous clear of the address counter while idle |
| switchVal | input | DATA_W | Value to store |
| memAddr | output | ADDR_W | Address to the memory |
| memChipSel | output | 1 | Memory chip select, active high |
| memWriteEn | output | 1 | Memory write enable, active high |
| memDataOut | output | DATA_W | Data driven toward the memory |
| memDataOutEn | output | 1 | Enable of the data drive buffer |
| memDataIn | input | DATA_W | Data read from the memory |
| dispVal | output | DATA_W | Display holding register |
| addrMonitor | output | ADDR_W | Copy of the address counter for display |
| busy | output | 1 | High while a cycle is running |

## Verification
The hardest cases to reach from the ports are presses and clears that arrive while a cycle is already running. They are timed by clock count from the start of the cycle. The bench raises a second press edge in the middle of a cycle, pulses the clear input in period 1, and in one case holds the button down through the whole cycle. After each of these it checks that only one cycle ran and that the address moved only as the step option dictates. The 15-to-0 wrap is reached by stepping through all sixteen locations with writes and then reading them all back.

// File: rtl/mexr_pkg.sv
package mexr_pkg;

  localparam int NUM_PERIODS = 7;

  localparam logic [2:0] CS_FIRST     = 3'd1;
  localparam logic [2:0] CS_LAST      = 3'd5;
  localparam logic [2:0] WE_FIRST     = 3'd2;
  localparam logic [2:0] WE_LAST      = 3'd4;
  localparam logic [2:0] DRIVE_PERIOD = 3'd3;
  localparam logic [2:0] LOAD_PERIOD  = 3'd5;
  localparam logic [2:0] STEP_PERIOD  = 3'd6;

  typedef struct packed {
    logic chipSel;
    logic writeEn;
    logic driveEn;
    logic loadHold;
    logic stepAddr;
    logic clearAddr;
  } strobes_t;

endpackage

// File: rtl/mexr_ctrl.sv
module mexr_ctrl
  import mexr_pkg::*;
#(
  parameter int PHASE_CYCLES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pressIn,
  input  logic     writeSel,
  input  logic     stepEn,
  input  logic     clearIn,
  output strobes_t strobes,
  output logic     busy
);

  localparam int SUB_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PHASE_CYCLES - 1);

  logic             active;
  logic [2:0]       period;
  logic [SUB_W-1:0] sub;
  logic             pressPrev;
  logic             isWrite;
  logic             doStep;
  logic             pressEdge;
  logic             lastSub;

  assign pressEdge = pressIn && !pressPrev;
  assign lastSub   = (sub == SUB_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      period    <= '0;
      sub       <= '0;
      pressPrev <= 1'b0;
      isWrite   <= 1'b0;
      doStep    <= 1'b0;
    end else begin
      pressPrev <= pressIn;
      if (!active) begin
        if (pressEdge) begin
          active  <= 1'b1;
          period  <= '0;
          sub     <= '0;
          isWrite <= writeSel;
          doStep  <= stepEn;
        end
      end else if (lastSub) begin
        sub <= '0;
        if (period == STEP_PERIOD) begin
          active <= 1'b0;
          period <= '0;
        end else begin
          period <= period + 3'd1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  function automatic logic inWindow(input logic [2:0] p, input logic [2:0] lo,
                                    input logic [2:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction

  always_comb begin
    strobes.chipSel   = active && inWindow(period, CS_FIRST, CS_LAST);
    strobes.writeEn   = active && isWrite && inWindow(period, WE_FIRST, WE_LAST);
    strobes.driveEn   = active && isWrite && (period == DRIVE_PERIOD);
    strobes.loadHold  = active && !isWrite && (period == LOAD_PERIOD) && lastSub;
    strobes.stepAddr  = active && doStep && (period == STEP_PERIOD) && lastSub;
    strobes.clearAddr = !active && clearIn;
  end

  assign busy = active;

endmodule

// File: rtl/mexr_dpath.sv
module mexr_dpath
  import mexr_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] switchVal,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] addrCount,
  output logic [DATA_W-1:0] holdReg,
  output logic [DATA_W-1:0] driveData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCount <= '0;
    end else if (strobes.clearAddr) begin
      addrCount <= '0;
    end else if (strobes.stepAddr) begin
      addrCount <= addrCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobes.loadHold) begin
      holdReg <= memDataIn;
    end
  end

  assign driveData = strobes.driveEn ? switchVal : '0;

endmodule

// File: rtl/mem_exerciser.sv
module mem_exerciser
  import mexr_pkg::*;
#(
  parameter int DATA_W       = 4,
  parameter int ADDR_W       = 4,
  parameter int PHASE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pressIn,
  input  logic              writeSel,
  input  logic              stepEn,
  input  logic              clearIn,
  input  logic [DATA_W-1:0] switchVal,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memChipSel,
  output logic              memWriteEn,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOutEn,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [DATA_W-1:0] dispVal,
  output logic [ADDR_W-1:0] addrMonitor,
  output logic              busy
);

  strobes_t          strobes;
  logic [ADDR_W-1:0] addrCount;

  mexr_ctrl #(.PHASE_CYCLES(PHASE_CYCLES)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pressIn  (pressIn),
    .writeSel (writeSel),
    .stepEn   (stepEn),
    .clearIn  (clearIn),
    .strobes  (strobes),
    .busy     (busy)
  );

  mexr_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .switchVal (switchVal),
    .memDataIn (memDataIn),
    .addrCount (addrCount),
    .holdReg   (dispVal),
    .driveData (memDataOut)
  );

  assign memAddr      = addrCount;
  assign addrMonitor  = addrCount;
  assign memChipSel   = strobes.chipSel;
  assign memWriteEn   = strobes.writeEn;
  assign memDataOutEn = strobes.driveEn;

endmodule

// File: rtl/mem_exerciser_checker.sv
module mem_exerciser_checker #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearIn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memChipSel,
  input logic              memWriteEn,
  input logic              memDataOutEn,
  input logic [DATA_W-1:0] dispVal,
  input logic              busy
);

  assert_cs_inside_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    memChipSel |-> busy);

  assert_cs_release_before_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memChipSel) |-> busy);

  assert_we_inside_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWriteEn |-> memChipSel);

  assert_drive_inside_we_R5: assert property (@(posedge clk) disable iff (!rstN)
    memDataOutEn |-> memWriteEn);

  assert_disp_idle_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(dispVal));

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr));

  assert_clear_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clearIn && !busy) |=> (memAddr == '0));

endmodule

bind mem_exerciser mem_exerciser_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (
  .clk          (clk),
  .rstN         (rstN),
  .clearIn      (clearIn),
  .memAddr      (memAddr),
  .memChipSel   (memChipSel),
  .memWriteEn   (memWriteEn),
  .memDataOutEn (memDataOutEn),
  .dispVal      (dispVal),
  .busy         (busy)
);

// File: tb/mem_exerciser_test.sv
module mem_exerciser_test;

  localparam int P   = 2;
  localparam int TOT = 7 * P;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pressIn = 1'b0;
  logic       writeSel = 1'b0;
  logic       stepEn = 1'b0;
  logic       clearIn = 1'b0;
  logic [3:0] switchVal = 4'h0;
  logic [3:0] memAddr;
  logic       memChipSel;
  logic       memWriteEn;
  logic [3:0] memDataOut;
  logic       memDataOutEn;
  logic [3:0] memDataIn;
  logic [3:0] dispVal;
  logic [3:0] addrMonitor;
  logic       busy;

  int errors = 0;
  int checks = 0;
  int cycleCount = 0;

  logic [3:0] memModel [16];
  logic [3:0] expMem [16];

  always #2 clk = ~clk;

  mem_exerciser #(.DATA_W(4), .ADDR_W(4), .PHASE_CYCLES(P)) uut (
    .clk(clk), .rstN(rstN), .pressIn(pressIn), .writeSel(writeSel),
    .stepEn(stepEn), .clearIn(clearIn), .switchVal(switchVal),
    .memAddr(memAddr), .memChipSel(memChipSel), .memWriteEn(memWriteEn),
    .memDataOut(memDataOut), .memDataOutEn(memDataOutEn), .memDataIn(memDataIn),
    .dispVal(dispVal), .addrMonitor(addrMonitor), .busy(busy)
  );

  assign memDataIn = (memChipSel && !memWriteEn) ? memModel[memAddr] : 4'h0;

  always @(negedge clk)
    if (memChipSel && memWriteEn && memDataOutEn) memModel[memAddr] <= memDataOut;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One full cycle, checked clock by clock against the period schedule.
  task automatic runCycle(input bit wr, input bit st, input logic [3:0] sw,
                          input bit holdPress, input bit extraPress, input bit midClear);
    logic [3:0] startAddr;
    logic [3:0] startDisp;
    logic [3:0] expAddr;
    startAddr = addrMonitor;
    startDisp = dispVal;
    @(negedge clk);
    writeSel = wr; stepEn = st; switchVal = sw; pressIn = 1'b1;
    @(negedge clk);
    if (!holdPress) pressIn = 1'b0;
    for (int idx = 0; idx < TOT; idx++) begin
      int per;
      per = idx / P;
      check(busy == 1'b1, "R2 busy during cycle", busy, 1);
      check(memChipSel == (per >= 1 && per <= 5), "R3 chip select window", memChipSel,
            (per >= 1 && per <= 5));
      check(memWriteEn == (wr && per >= 2 && per <= 4), "R4 write enable window",
            memWriteEn, (wr && per >= 2 && per <= 4));
      check(memDataOutEn == (wr && per == 3), "R5 drive window", memDataOutEn,
            (wr && per == 3));
      if (memDataOutEn) check(memDataOut == sw, "R5 drive value", memDataOut, sw);
      check(addrMonitor == startAddr && memAddr == startAddr, "R7 address stable",
            memAddr, startAddr);
      if (!wr && idx >= 6 * P)
        check(dispVal == expMem[startAddr], "R6 display loaded", dispVal, expMem[startAddr]);
      else
        check(dispVal == startDisp, "R6 display held", dispVal, startDisp);
      if (extraPress && idx == 4) pressIn = 1'b1;
      if (extraPress && idx == 6) pressIn = 1'b0;
      if (midClear && idx == 2) clearIn = 1'b1;
      if (midClear && idx == 3) clearIn = 1'b0;
      @(negedge clk);
    end
    if (wr) expMem[startAddr] = sw;
    expAddr = st ? startAddr + 4'd1 : startAddr;
    check(busy == 1'b0, "R2 cycle length", busy, 0);
    check(addrMonitor == expAddr, st ? "R7 step after cycle" : "R8 no step",
          addrMonitor, expAddr);
    if (midClear) check(addrMonitor == expAddr, "R10 clear ignored while busy",
                        addrMonitor, expAddr);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(busy == 1'b0, holdPress ? "R2 held press no restart" : "R9 no extra cycle",
            busy, 0);
    end
    pressIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check(addrMonitor == 4'd0 && memAddr == 4'd0, "R1 reset address", addrMonitor, 0);
    check(dispVal == 4'd0, "R1 reset display", dispVal, 0);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(!memChipSel && !memWriteEn && !memDataOutEn, "R1 reset strobes",
          {memChipSel, memWriteEn, memDataOutEn}, 0);
  endtask

  task automatic clearAddr();
    @(negedge clk);
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
    check(addrMonitor == 4'd0, "R10 clear while idle", addrMonitor, 0);
  endtask

  task automatic testWriteRead();
    runCycle(1'b1, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0);
    clearAddr();
    runCycle(1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0);
    check(dispVal == 4'h5, "R6 read back value", dispVal, 5);
  endtask

  task automatic testSweep();
    clearAddr();
    for (int a = 0; a < 16; a++) runCycle(1'b1, 1'b1, 4'(a * 7 + 3), 1'b0, 1'b0, 1'b0);
    check(addrMonitor == 4'd0, "R7 wrap after sweep", addrMonitor, 0);
    for (int a = 0; a < 16; a++) begin
      runCycle(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0);
      check(dispVal == 4'(a * 7 + 3), "R6 sweep read", dispVal, 4'(a * 7 + 3));
    end
  endtask

  task automatic testIgnored();
    runCycle(1'b1, 1'b1, 4'hC, 1'b0, 1'b1, 1'b0);
    runCycle(1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    runCycle(1'b1, 1'b1, 4'h9, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      memModel[i] = 4'(i ^ 10);
      expMem[i]   = 4'(i ^ 10);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteRead();
    testSweep();
    testIgnored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cycleCount, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule